// File: doc/BRIEF.md
# Digital Compare Event Generator

This block turns a small set of external trip inputs and analog comparator outputs into four qualified compare events for two PWM channels, A and B. Each channel owns two selected signals, a "high" and a "low" one. Each selected signal comes from a per-signal source select. Trip inputs pass through a programmable polarity before selection. Comparator outputs are used as they are.

Two events per channel (A1, A2, B1, B2) are built from that channel's signal pair. Each event has its own 3-bit condition code. A per-event mux then takes either the qualified raw event or an externally filtered copy of it.

Every event fans out to four consumers at once:
- a trip force level, which is combinational so that trip action is immediate;
- a latched interrupt flag with enable and clear, which feeds one shared trip interrupt line;
- an ADC start-of-conversion request, where A1 feeds request A and B1 feeds request B;
- the counter sync pulse, formed from A1 and B1 ORed with the external sync input and a software sync bit.

The requests and the sync are one-cycle pulses made from rising edges of the events.

Top module: `dcmp_event_gen`

## Requirements
- R1: The signal index order is A-high, A-low, B-high, B-low. Each signal has a select field in `sig_sel`, and signal n uses bits [3n+2:3n]. Select values 0..2 pick trip inputs 0..2. Values 3..5 pick comparator outputs 0..2. Values 6 and 7 give a constant 0.
- R2: Setting `trip_pol[i]` to 1 makes trip input i active low, so it is inverted before selection. Comparator outputs are never inverted.
- R3: Events A1 and A2 use the A pair, and B1 and B2 use the B pair. Event order is A1, A2, B1, B2, and event e uses `qual_code[3e+2:3e]`. In the codes below, H is the pair's high signal and L is its low signal:
  - 0: off
  - 1: H low
  - 2: H high
  - 3: L low
  - 4: L high
  - 5: H low and L high
  - 6 and 7: off
- R4: With `filt_sel[e]` at 1, event e equals `filt_evt[e]` and the qualified raw value has no effect. With `filt_sel[e]` at 0, the filtered input has no effect.
- R5: `evt_force[e]` reflects event e in the same cycle as its inputs, with no register on the way.
- R6: A rising edge of event e with `int_en[e]` set sets `evt_flag[e]` at the next clock edge. A rising edge with `int_en[e]` clear leaves the flag unchanged. `irq` is the OR of all flags.
- R7: A set flag holds until `int_clr[e]` is 1 at a clock edge, and then reads 0 after that edge. If a rising edge and a clear occur in the same cycle, the flag ends up set.
- R8: `soc_a` is a one-cycle pulse one clock after a rising edge of A1 when `soc_a_en` is 1. `soc_b` behaves the same way for B1 and `soc_b_en`. With the enable at 0, no pulse is produced.
- R9: `ctr_sync` is 1 one clock after a cycle in which `sync_in`, `sw_sync`, a rising edge of A1 or a rising edge of B1 was present.
- R10: Synchronous active-high reset clears all flags, `irq`, `soc_a`, `soc_b` and `ctr_sync`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trip_in | input | N_TRIP | External trip inputs |
| trip_pol | input | N_TRIP | Per-trip polarity, 1 = active low |
| cmp_in | input | N_CMP | Analog comparator outputs |
| sig_sel | input | 4*SEL_W | Source select of A-high, A-low, B-high, B-low |
| qual_code | input | 12 | Condition code of A1, A2, B1, B2 |
| filt_sel | input | 4 | Per-event choice of filtered path |
| filt_evt | input | 4 | Externally filtered event copies |
| int_en | input | 4 | Per-event interrupt enable |
| int_clr | input | 4 | Per-event flag clear strobe |
| soc_a_en | input | 1 | A1 drives ADC request A |
| soc_b_en | input | 1 | B1 drives ADC request B |
| sync_in | input | 1 | External sync input |
| sw_sync | input | 1 | Software force-sync bit |
| evt_force | output | 4 | Trip force level per event |
| evt_flag | output | 4 | Latched interrupt flags |
| irq | output | 1 | Shared trip interrupt |
| soc_a | output | 1 | ADC start-of-conversion A pulse |
| soc_b | output | 1 | ADC start-of-conversion B pulse |
| ctr_sync | output | 1 | Counter sync pulse |

## Verification
A wrong select, polarity or condition decode shows on `evt_force` in the very cycle the inputs are applied, so every code is walked against all four states of the pair. A stale edge register shows one clock later, either as a missing or doubled `soc_a`/`soc_b`/`ctr_sync` pulse or as a flag that sets without a fresh edge. Flag state errors become visible one edge after the offending enable or clear, including the case where an event and a clear collide.

// File: rtl/dcmp_pkg.sv
package dcmp_pkg;

    localparam int NUM_EVT  = 4;
    localparam int NUM_SIG  = 4;
    localparam int QUAL_W   = 3;

    typedef enum logic [1:0] {
        EV_A1 = 2'd0,
        EV_A2 = 2'd1,
        EV_B1 = 2'd2,
        EV_B2 = 2'd3
    } evt_id_e;

    typedef enum logic [QUAL_W-1:0] {
        Q_OFF        = 3'd0,
        Q_HI_LOW     = 3'd1,
        Q_HI_HIGH    = 3'd2,
        Q_LO_LOW     = 3'd3,
        Q_LO_HIGH    = 3'd4,
        Q_HLOW_LHIGH = 3'd5
    } qual_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } sig_pair_t;

    function automatic logic qualify(logic [QUAL_W-1:0] code, sig_pair_t p);
        logic r;
        case (code)
            Q_HI_LOW:     r = ~p.hi;
            Q_HI_HIGH:    r = p.hi;
            Q_LO_LOW:     r = ~p.lo;
            Q_LO_HIGH:    r = p.lo;
            Q_HLOW_LHIGH: r = ~p.hi & p.lo;
            default:      r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dcmp_src_sel.sv
module dcmp_src_sel #(
    parameter int N_TRIP = 3,
    parameter int N_CMP  = 3,
    parameter int SEL_W  = 3
) (
    input  logic [N_TRIP-1:0] trip_in,
    input  logic [N_TRIP-1:0] trip_pol,
    input  logic [N_CMP-1:0]  cmp_in,
    input  logic [SEL_W-1:0]  sel,
    output logic              sig
);
    localparam int NSRC     = N_TRIP + N_CMP;
    localparam int NSRC_PAD = 1 << SEL_W;

    logic [NSRC_PAD-1:0] src_pad;

    always_comb begin
        src_pad = '0;
        src_pad[NSRC-1:0] = {cmp_in, trip_in ^ trip_pol};
    end

    assign sig = src_pad[sel];
endmodule

// File: rtl/dcmp_qual.sv
module dcmp_qual
    import dcmp_pkg::*;
(
    input  logic [QUAL_W-1:0] code,
    input  sig_pair_t         pair,
    input  logic              use_filt,
    input  logic              filt,
    output logic              lvl
);
    logic raw;

    assign raw = qualify(code, pair);
    assign lvl = use_filt ? filt : raw;
endmodule

// File: rtl/dcmp_evt_out.sv
module dcmp_evt_out
    import dcmp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt_lvl,
    input  logic [NUM_EVT-1:0] int_en,
    input  logic [NUM_EVT-1:0] int_clr,
    input  logic               soc_a_en,
    input  logic               soc_b_en,
    input  logic               sync_in,
    input  logic               sw_sync,
    output logic [NUM_EVT-1:0] evt_flag,
    output logic               irq,
    output logic               soc_a,
    output logic               soc_b,
    output logic               ctr_sync
);
    localparam int IA1 = int'(EV_A1);
    localparam int IB1 = int'(EV_B1);

    logic [NUM_EVT-1:0] lvl_q;
    logic [NUM_EVT-1:0] rise;

    assign rise = evt_lvl & ~lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q    <= '0;
            evt_flag <= '0;
            soc_a    <= 1'b0;
            soc_b    <= 1'b0;
            ctr_sync <= 1'b0;
        end else begin
            lvl_q    <= evt_lvl;
            // a fresh edge outranks a clear in the same cycle
            evt_flag <= (evt_flag & ~int_clr) | (rise & int_en);
            soc_a    <= rise[IA1] & soc_a_en;
            soc_b    <= rise[IB1] & soc_b_en;
            ctr_sync <= sync_in | sw_sync | rise[IA1] | rise[IB1];
        end
    end

    assign irq = |evt_flag;
endmodule

// File: rtl/dcmp_event_gen.sv
module dcmp_event_gen
    import dcmp_pkg::*;
#(
    parameter int N_TRIP = 3,
    parameter int N_CMP  = 3,
    localparam int SEL_W = $clog2(N_TRIP + N_CMP + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_TRIP-1:0]         trip_in,
    input  logic [N_TRIP-1:0]         trip_pol,
    input  logic [N_CMP-1:0]          cmp_in,
    input  logic [NUM_SIG*SEL_W-1:0]  sig_sel,
    input  logic [NUM_EVT*QUAL_W-1:0] qual_code,
    input  logic [NUM_EVT-1:0]        filt_sel,
    input  logic [NUM_EVT-1:0]        filt_evt,
    input  logic [NUM_EVT-1:0]        int_en,
    input  logic [NUM_EVT-1:0]        int_clr,
    input  logic                      soc_a_en,
    input  logic                      soc_b_en,
    input  logic                      sync_in,
    input  logic                      sw_sync,
    output logic [NUM_EVT-1:0]        evt_force,
    output logic [NUM_EVT-1:0]        evt_flag,
    output logic                      irq,
    output logic                      soc_a,
    output logic                      soc_b,
    output logic                      ctr_sync
);
    logic [NUM_SIG-1:0] sig;
    logic [NUM_EVT-1:0] evt_lvl;

    for (genvar s = 0; s < NUM_SIG; s++) begin : g_sig
        dcmp_src_sel #(.N_TRIP(N_TRIP), .N_CMP(N_CMP), .SEL_W(SEL_W)) u_sel (
            .trip_in (trip_in),
            .trip_pol(trip_pol),
            .cmp_in  (cmp_in),
            .sel     (sig_sel[s*SEL_W +: SEL_W]),
            .sig     (sig[s])
        );
    end

    for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
        localparam int CH = e / 2;
        sig_pair_t pair;
        assign pair.hi = sig[2*CH];
        assign pair.lo = sig[2*CH+1];

        dcmp_qual u_qual (
            .code    (qual_code[e*QUAL_W +: QUAL_W]),
            .pair    (pair),
            .use_filt(filt_sel[e]),
            .filt    (filt_evt[e]),
            .lvl     (evt_lvl[e])
        );
    end

    assign evt_force = evt_lvl;

    dcmp_evt_out u_out (
        .clk     (clk),
        .rst     (rst),
        .evt_lvl (evt_lvl),
        .int_en  (int_en),
        .int_clr (int_clr),
        .soc_a_en(soc_a_en),
        .soc_b_en(soc_b_en),
        .sync_in (sync_in),
        .sw_sync (sw_sync),
        .evt_flag(evt_flag),
        .irq     (irq),
        .soc_a   (soc_a),
        .soc_b   (soc_b),
        .ctr_sync(ctr_sync)
    );
endmodule

// File: rtl/dcmp_event_chk.sv
module dcmp_event_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] evt_force,
    input logic [3:0] evt_flag,
    input logic [3:0] int_en,
    input logic [3:0] int_clr,
    input logic       soc_a,
    input logic       soc_b,
    input logic       soc_a_en,
    input logic       soc_b_en,
    input logic       sync_in,
    input logic       sw_sync,
    input logic       ctr_sync
);
    // R6: a flag may only newly appear where its enable was set
    assert_flag_needs_en_R6: assert property (@(posedge clk) disable iff (rst)
        ((evt_flag & ~$past(evt_flag) & ~$past(int_en)) == 4'b0));

    // R7: without a clear, a set flag stays set
    assert_flag_hold_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((evt_flag & $past(evt_flag & ~int_clr)) == $past(evt_flag & ~int_clr)));

    // R8: request pulses last one cycle and need event plus enable
    assert_soc_a_single_R8: assert property (@(posedge clk) disable iff (rst)
        soc_a |=> !soc_a);
    assert_soc_a_cause_R8: assert property (@(posedge clk) disable iff (rst)
        soc_a |-> ($past(evt_force[0]) && $past(soc_a_en)));
    assert_soc_b_cause_R8: assert property (@(posedge clk) disable iff (rst)
        soc_b |-> ($past(evt_force[2]) && $past(soc_b_en)));

    // R9: any external sync source yields a counter sync next cycle
    assert_sync_src_R9: assert property (@(posedge clk) disable iff (rst)
        (sync_in || sw_sync) |=> ctr_sync);
endmodule

bind dcmp_event_gen dcmp_event_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .evt_force(evt_force),
    .evt_flag (evt_flag),
    .int_en   (int_en),
    .int_clr  (int_clr),
    .soc_a    (soc_a),
    .soc_b    (soc_b),
    .soc_a_en (soc_a_en),
    .soc_b_en (soc_b_en),
    .sync_in  (sync_in),
    .sw_sync  (sw_sync),
    .ctr_sync (ctr_sync)
);

// File: tb/sim_dcmp_event_gen.sv
module sim_dcmp_event_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  trip_in = '0, trip_pol = '0, cmp_in = '0;
    logic [11:0] sig_sel = '0, qual_code = '0;
    logic [3:0]  filt_sel = '0, filt_evt = '0, int_en = '0, int_clr = '0;
    logic        soc_a_en = 1'b0, soc_b_en = 1'b0, sync_in = 1'b0, sw_sync = 1'b0;
    logic [3:0]  evt_force, evt_flag;
    logic        irq, soc_a, soc_b, ctr_sync;

    always #2 clk = ~clk; // 250 MHz

    dcmp_event_gen u0 (
        .clk(clk), .rst(rst), .trip_in(trip_in), .trip_pol(trip_pol), .cmp_in(cmp_in),
        .sig_sel(sig_sel), .qual_code(qual_code), .filt_sel(filt_sel), .filt_evt(filt_evt),
        .int_en(int_en), .int_clr(int_clr), .soc_a_en(soc_a_en), .soc_b_en(soc_b_en),
        .sync_in(sync_in), .sw_sync(sw_sync), .evt_force(evt_force), .evt_flag(evt_flag),
        .irq(irq), .soc_a(soc_a), .soc_b(soc_b), .ctr_sync(ctr_sync)
    );

    // observed bits: [11:8] force, [7:4] flags, 3 irq, 2 soc_a, 1 soc_b, 0 sync
    logic [11:0] obs;
    assign obs = {evt_force, evt_flag, irq, soc_a, soc_b, ctr_sync};

    typedef struct {
        int          cyc;
        string       req;
        logic [11:0] mask;
        logic [11:0] exp;
    } item_t;

    item_t sbq[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(int ofs, string req, logic [11:0] mask, logic [11:0] exp);
        item_t it;
        it.cyc = cyc + ofs; it.req = req; it.mask = mask; it.exp = exp & mask;
        sbq.push_back(it);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // monitor: scoreboard pop and compare
    always @(negedge clk) begin
        #1;
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].cyc == cyc) begin
                checks++;
                if ((obs & sbq[i].mask) !== sbq[i].exp) begin
                    errors++;
                    $display("FAIL %s cycle %0d: actual %03h expected %03h (mask %03h)",
                             sbq[i].req, cyc, obs & sbq[i].mask, sbq[i].exp, sbq[i].mask);
                end
                sbq.delete(i);
            end
        end
    end

    function automatic bit ref_q(int code, bit h, bit l);
        case (code)
            1: return !h;
            2: return h;
            3: return !l;
            4: return l;
            5: return !h && l;
            default: return 1'b0;
        endcase
    endfunction

    task automatic quiet();
        trip_in = '0; trip_pol = '0; cmp_in = '0; qual_code = '0;
        filt_sel = '0; filt_evt = '0; int_en = '0; int_clr = '0;
        soc_a_en = 0; soc_b_en = 0; sync_in = 0; sw_sync = 0;
        // A-hi=trip0, A-lo=trip1, B-hi=cmp0 (3), B-lo=cmp1 (4)
        sig_sel = {3'd4, 3'd3, 3'd1, 3'd0};
    endtask

    initial begin
        quiet();
        repeat (3) tick();
        rst = 1'b0;
        expect_at(0, "R10", 12'hFFF, 12'h000);               // R10
        tick();
        // R5 force same cycle, R8 soc_a, R9 sync, R6 no flag when disabled
        qual_code[2:0] = 3'd2; soc_a_en = 1; trip_in = 3'b001;
        expect_at(0, "R5", 12'h100, 12'h100);                // R5
        expect_at(1, "R8", 12'h004, 12'h004);                // R8
        expect_at(1, "R9", 12'h001, 12'h001);                // R9
        expect_at(1, "R6", 12'h0F8, 12'h000);                // R6
        tick();
        expect_at(1, "R8", 12'h004, 12'h000);                // R8 single pulse
        expect_at(1, "R9", 12'h001, 12'h000);                // R9
        tick();
        // R2 polarity
        soc_a_en = 0; trip_pol[0] = 1;
        expect_at(0, "R2", 12'h100, 12'h000);                // R2
        tick();
        trip_in = 3'b000;
        expect_at(0, "R2", 12'h100, 12'h100);                // R2
        tick();
        quiet();
        // R3 all codes against all pair states
        for (int c = 0; c < 8; c++) begin
            for (int hl = 0; hl < 4; hl++) begin
                tick();
                qual_code[2:0] = 3'(c);
                trip_in[0] = hl[1]; trip_in[1] = hl[0];
                expect_at(0, "R3", 12'h100, {3'b0, ref_q(c, hl[1], hl[0]), 8'h00}); // R3
            end
        end
        tick(); quiet();
        // R1 source select
        qual_code[2:0] = 3'd2; sig_sel[2:0] = 3'd4; cmp_in = 3'b010;
        expect_at(0, "R1", 12'h100, 12'h100);                // R1
        tick();
        cmp_in = 3'b101; trip_in = 3'b111;
        expect_at(0, "R1", 12'h100, 12'h000);                // R1
        tick();
        sig_sel[2:0] = 3'd6; cmp_in = 3'b111;
        expect_at(0, "R1", 12'h100, 12'h000);                // R1 unused select
        tick();
        quiet(); qual_code[8:6] = 3'd2; cmp_in = 3'b001; qual_code[2:0] = 3'd2;
        expect_at(0, "R1", 12'h500, 12'h400);                // R1 B1 from cmp0
        tick(); quiet();
        // R4 filtered path
        filt_sel = 4'b0010; filt_evt = 4'b0010;
        expect_at(0, "R4", 12'h200, 12'h200);                // R4
        tick();
        filt_evt = 4'b0000;
        expect_at(0, "R4", 12'h200, 12'h000);                // R4
        tick();
        filt_sel = 4'b0000; filt_evt = 4'b1111;
        expect_at(0, "R4", 12'hF00, 12'h000);                // R4 unselected ignored
        tick();
        filt_sel = 4'b0001; filt_evt = 4'b0000; qual_code[2:0] = 3'd2; trip_in = 3'b001;
        expect_at(0, "R4", 12'h100, 12'h000);                // R4 raw ignored
        tick(); quiet();
        // R6 / R7 flags
        int_en = 4'b1000; qual_code[11:9] = 3'd2;
        tick();
        cmp_in = 3'b001;
        expect_at(1, "R6", 12'h0F8, 12'h088);                // R6
        tick();
        expect_at(1, "R7", 12'h0F8, 12'h088);                // R7 hold
        tick();
        int_clr = 4'b1000;
        expect_at(1, "R7", 12'h0F8, 12'h000);                // R7 clear
        tick();
        int_clr = 4'b0000; cmp_in = 3'b000;
        expect_at(1, "R7", 12'h0F8, 12'h000);                // R7
        tick();
        cmp_in = 3'b001; int_clr = 4'b1000;
        expect_at(1, "R7", 12'h0F8, 12'h088);                // R7 event wins
        tick();
        int_clr = 4'b0000;
        expect_at(1, "R7", 12'h0F8, 12'h088);                // R7
        tick();
        quiet(); int_clr = 4'b1111;
        tick(); quiet();
        // R8 soc_b
        qual_code[8:6] = 3'd2; soc_b_en = 1;
        tick();
        cmp_in = 3'b001;
        expect_at(1, "R8", 12'h006, 12'h002);                // R8
        expect_at(1, "R9", 12'h001, 12'h001);                // R9 from B1
        tick();
        expect_at(1, "R8", 12'h002, 12'h000);                // R8
        tick();
        cmp_in = 3'b000;
        tick();
        soc_b_en = 0; cmp_in = 3'b001;
        expect_at(1, "R8", 12'h002, 12'h000);                // R8 disabled
        expect_at(1, "R9", 12'h001, 12'h001);                // R9
        tick(); quiet();
        // R9 external sources
        tick();
        sync_in = 1;
        expect_at(1, "R9", 12'h001, 12'h001);                // R9
        tick();
        sync_in = 0; sw_sync = 1;
        expect_at(1, "R9", 12'h001, 12'h001);                // R9
        tick();
        sw_sync = 0;
        expect_at(1, "R9", 12'h001, 12'h000);                // R9
        repeat (3) tick();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule